// File: doc/BRIEF.md
# Presettable Decade/Binary Up-Down Digit Counter

This block is a single-digit synchronous counter holding a 4-bit value. A radix input chooses the counting modulus: with it low the digit counts in BCD over 0..9, and with it high it counts as a plain 4-bit binary value over 0..15. A direction input picks up or down counting. An active-low enable input gates the advance. A load input copies four parallel data bits into the digit. A reset input clears the digit and wins over everything else.

An active-low carry output signals that the digit sits at the last value for its current direction while it is enabled. Wiring one digit's carry output to the next digit's enable input, with every digit on the same clock, gives a multi-digit decimal or hexadecimal counter. In decade mode, a digit that holds one of the six codes above 9 (after a load, for instance) follows a fixed recovery path. It is back inside 0..9 after at most two clocks when counting up, and after at most three clocks when counting down.

Top module: `digit_counter_updn`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `q` becomes 0 on that edge, whatever `load`, `cin_n` and the other inputs hold.
- R2: With `rst` 0 and `load` 1 at a rising edge, `q` takes the value of `jam` on that edge, whether `cin_n` is 0 or 1.
- R3: With `rst` 0, `load` 0 and `cin_n` 1 at a rising edge, `q` keeps its value.
- R4: In binary mode (`bin_mode` = 1) an enabled edge adds one modulo 16 when `up` = 1 (15 goes to 0) and subtracts one modulo 16 when `up` = 0 (0 goes to 15).
- R5: In decade mode (`bin_mode` = 0) with `q` in 0..9, an enabled edge counts up 0..9 with 9 going to 0, or counts down 9..0 with 0 going to 9, so `q` stays in 0..9.
- R6: `cout_n` is 0 exactly when `cin_n` is 0 and `q` is the terminal value for the present direction and radix: 15 for binary up, 9 for decade up, 0 for down in either radix. Otherwise it is 1. The output is combinational from `q` and the control inputs.
- R7: In decade mode, counting up from a code in 10..15 moves an even code to the code plus one and an odd code to 0, so `q` is legal within two enabled edges.
- R8: In decade mode, counting down from a code in 10..15 subtracts two per enabled edge. Odd codes reach 9 and even codes reach 8, within three enabled edges.
- R9: Two digits on one clock, with the low digit's `cout_n` driving the high digit's `cin_n`, count 00..99 in decade mode and wrap in both directions (99 up to 00, 00 down to 99).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| cin_n | input | 1 | Active-low count enable / carry in |
| up | input | 1 | 1 counts up, 0 counts down |
| bin_mode | input | 1 | 1 binary modulo 16, 0 decade modulo 10 |
| load | input | 1 | Active-high synchronous parallel load |
| jam | input | 4 | Parallel load value |
| q | output | 4 | Present count |
| cout_n | output | 1 | Active-low terminal-count carry out |

## Verification
The hardest states to reach from the ports are the six decade codes above 9. Counting in decade mode never produces them, so the stimulus loads each of them through `jam` in decade mode. It then counts up and down from each one and follows the recovery path edge by edge. The two-digit chain is driven through full up and down sweeps, so the high digit's enable only arrives through the low digit's carry. A reference model in the bench predicts both digits and the carry on every clock.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam int DEC_TOP = 9;
    localparam int BIN_TOP = (1 << DIGIT_W) - 1;
    localparam int DN_RECOVER_STEP = 2;

    typedef logic [DIGIT_W-1:0] nib_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        RADIX_DEC = 1'b0,
        RADIX_BIN = 1'b1
    } radix_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    typedef struct packed {
        act_e   act;
        dir_e   dir;
        radix_e radix;
        logic   en;
    } ctl_t;

    function automatic logic dec_legal(input nib_t v);
        return v <= nib_t'(DEC_TOP);
    endfunction

    function automatic nib_t term_value(input dir_e d, input radix_e r);
        if (d == DIR_DOWN)
            return '0;
        else if (r == RADIX_BIN)
            return nib_t'(BIN_TOP);
        else
            return nib_t'(DEC_TOP);
    endfunction

endpackage

// File: rtl/dcnt_ctl.sv
module dcnt_ctl
    import cnt_pkg::*;
(
    input  logic rst,
    input  logic load,
    input  logic cin_n,
    input  logic up,
    input  logic bin_mode,
    output ctl_t ctl
);
    always_comb begin
        ctl.dir   = up ? DIR_UP : DIR_DOWN;
        ctl.radix = bin_mode ? RADIX_BIN : RADIX_DEC;
        ctl.en    = ~cin_n;
        if (rst)
            ctl.act = ACT_CLEAR;
        else if (load)
            ctl.act = ACT_LOAD;
        else if (~cin_n)
            ctl.act = ACT_STEP;
        else
            ctl.act = ACT_HOLD;
    end
endmodule

// File: rtl/dcnt_next.sv
module dcnt_next
    import cnt_pkg::*;
#(
    parameter int STEP_DN_ILLEGAL = DN_RECOVER_STEP
) (
    input  nib_t q,
    input  ctl_t ctl,
    output nib_t step_val
);
    nib_t inc, dec, bin_v, dec_v;

    always_comb begin
        inc = q + nib_t'(1);
        dec = q - nib_t'(1);
        bin_v = (ctl.dir == DIR_UP) ? inc : dec;
    end

    always_comb begin
        if (dec_legal(q)) begin
            if (ctl.dir == DIR_UP)
                dec_v = (q == nib_t'(DEC_TOP)) ? '0 : inc;
            else
                dec_v = (q == '0) ? nib_t'(DEC_TOP) : dec;
        end else begin
            if (ctl.dir == DIR_UP)
                dec_v = q[0] ? '0 : inc;
            else
                dec_v = q - nib_t'(STEP_DN_ILLEGAL);
        end
    end

    generate
        if (DIGIT_W == 4) begin : g_mux
            assign step_val = (ctl.radix == RADIX_BIN) ? bin_v : dec_v;
        end else begin : g_bin_only
            assign step_val = bin_v;
        end
    endgenerate
endmodule

// File: rtl/dcnt_term.sv
module dcnt_term
    import cnt_pkg::*;
(
    input  nib_t q,
    input  ctl_t ctl,
    output logic cout_n
);
    nib_t tv;
    always_comb begin
        tv = term_value(ctl.dir, ctl.radix);
        cout_n = ~(ctl.en && (q == tv));
    end
endmodule

// File: rtl/digit_counter_updn.sv
module digit_counter_updn
    import cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cin_n,
    input  logic       up,
    input  logic       bin_mode,
    input  logic       load,
    input  logic [3:0] jam,
    output logic [3:0] q,
    output logic       cout_n
);
    ctl_t ctl;
    nib_t cnt_q;
    nib_t step_val;

    dcnt_ctl u_ctl (
        .rst      (rst),
        .load     (load),
        .cin_n    (cin_n),
        .up       (up),
        .bin_mode (bin_mode),
        .ctl      (ctl)
    );

    dcnt_next u_next (
        .q        (cnt_q),
        .ctl      (ctl),
        .step_val (step_val)
    );

    dcnt_term u_term (
        .q      (cnt_q),
        .ctl    (ctl),
        .cout_n (cout_n)
    );

    always_ff @(posedge clk) begin
        unique case (ctl.act)
            ACT_CLEAR: cnt_q <= '0;
            ACT_LOAD:  cnt_q <= jam;
            ACT_STEP:  cnt_q <= step_val;
            default:   cnt_q <= cnt_q;
        endcase
    end

    assign q = cnt_q;
endmodule

// File: rtl/digit_counter_updn_chk.sv
module digit_counter_updn_chk (
    input logic       clk,
    input logic       rst,
    input logic       cin_n,
    input logic       up,
    input logic       bin_mode,
    input logic       load,
    input logic [3:0] jam,
    input logic [3:0] q,
    input logic       cout_n
);
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(jam));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cin_n) |=> $stable(q));

    p_bin_up_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && bin_mode && up) |=> q == 4'($past(q) + 4'd1));

    p_dec_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && !bin_mode && q <= 4'd9) |=> q <= 4'd9);

    p_carry_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !cout_n |-> !cin_n);

    p_dn_recover_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && !bin_mode && !up && q > 4'd9)
            |=> q == 4'($past(q) - 4'd2));
endmodule

bind digit_counter_updn digit_counter_updn_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cin_n    (cin_n),
    .up       (up),
    .bin_mode (bin_mode),
    .load     (load),
    .jam      (jam),
    .q        (q),
    .cout_n   (cout_n)
);

// File: tb/test_digit_counter_updn.sv
module test_digit_counter_updn;
    logic       clk = 1'b0;
    logic       rst = 1'b1, cin_n = 1'b1, up = 1'b1, bin_mode = 1'b0, load = 1'b0;
    logic [3:0] jam = 4'd0;
    logic [3:0] q_lo, q_hi;
    logic       co_lo, co_hi;

    int n_chk = 0, n_bad = 0;
    int m_lo = 0, m_hi = 0;

    always #10 clk = ~clk;

    digit_counter_updn i_digit_counter_updn (
        .clk(clk), .rst(rst), .cin_n(cin_n), .up(up), .bin_mode(bin_mode),
        .load(load), .jam(jam), .q(q_lo), .cout_n(co_lo));

    digit_counter_updn i_tens (
        .clk(clk), .rst(rst), .cin_n(co_lo), .up(up), .bin_mode(bin_mode),
        .load(load), .jam(jam), .q(q_hi), .cout_n(co_hi));

    function automatic int ref_step(int v, bit u, bit b);
        if (b) return u ? (v + 1) % 16 : (v + 15) % 16;
        if (v <= 9) begin
            if (u) return (v == 9) ? 0 : v + 1;
            return (v == 0) ? 9 : v - 1;
        end
        if (u) return (v % 2 == 0) ? v + 1 : 0;
        return v - 2;
    endfunction

    function automatic bit ref_carry_n(int v, bit en, bit u, bit b);
        int t;
        t = !u ? 0 : (b ? 15 : 9);
        return !(en && v == t);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(bit r, bit ld, bit cn, bit u, bit b, int j, string req);
        bit e_co_lo, e_co_hi;
        rst = r; load = ld; cin_n = cn; up = u; bin_mode = b; jam = 4'(j);
        #1;
        e_co_lo = ref_carry_n(m_lo, !cn, u, b);
        e_co_hi = ref_carry_n(m_hi, !e_co_lo, u, b);
        check({req, "/R6 carry lo"}, int'(co_lo), int'(e_co_lo));
        check({req, "/R9 carry hi"}, int'(co_hi), int'(e_co_hi));
        if (r) begin m_lo = 0; m_hi = 0; end
        else if (ld) begin m_lo = j; m_hi = j; end
        else begin
            if (!cn) m_lo = ref_step(m_lo, u, b);
            if (!e_co_lo) m_hi = ref_step(m_hi, u, b);
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " q lo"}, int'(q_lo), m_lo);
        check({req, "/R9 q hi"}, int'(q_hi), m_hi);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset wins over load and count
        cyc(1, 1, 0, 1, 0, 5, "R1");
        cyc(1, 0, 0, 0, 1, 0, "R1");
        // R2 load with enable off and on, R3 hold
        cyc(0, 1, 1, 1, 0, 7, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, i % 2, i % 2, 3, "R3");
        cyc(0, 1, 0, 0, 1, 12, "R2");
        cyc(0, 0, 1, 1, 1, 0, "R3");
        // R4 binary sweeps
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 1, 0, "R4");
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0, "R4");
        // R5 decade sweeps
        cyc(1, 0, 1, 1, 0, 0, "R1");
        for (int i = 0; i < 25; i++) cyc(0, 0, 0, 1, 0, 0, "R5");
        for (int i = 0; i < 25; i++) cyc(0, 0, 0, 0, 0, 0, "R5");
        // R7/R8 recovery from every illegal decade code
        for (int v = 10; v < 16; v++) begin
            cyc(0, 1, 1, 1, 0, v, "R2");
            for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, "R7");
            cyc(0, 1, 1, 0, 0, v, "R2");
            for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R8");
        end
        // R9 chained two-digit sweeps
        cyc(1, 0, 1, 1, 0, 0, "R1");
        for (int i = 0; i < 120; i++) cyc(0, 0, (i % 7 == 3), 1, 0, 0, "R9");
        for (int i = 0; i < 120; i++) cyc(0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 1, 0, 1, 0, "R1");
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 0, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule